// File: doc/BRIEF.md
# Serial Multiprocessor Address Filter

This block sits behind a UART receiver and decides whether each received byte raises the receive-interrupt flag. In a multidrop arrangement many receivers share one line, and each receiver should only wake its processor for bytes addressed to it. Software programs a slave address and a mask. Mask bits that are 1 are compared and mask bits that are 0 are don't-care. The block also derives a broadcast pattern from the same two registers.

Filtering is active only when the serial mode field is nonzero and the filter enable is set. While filtering is active, a byte sets the flag if it matches the masked individual address or covers every bit of the broadcast pattern. A byte that matches neither leaves the flag as it was. While filtering is inactive, every byte sets the flag. The flag stays set until software clears it.

Received bytes arrive on a valid/ready stream. The block never applies back-pressure: `rx_ready` is always high, so a byte is consumed in every cycle in which `rx_valid` is high. The mode, enable, register-write and clear pins are plain control inputs.

Top module: `uart_addr_filter`

## Requirements
- R1: While reset is asserted and on release, `rx_flag` is 0, and both the address register and the mask register hold 0.
- R2: `rx_ready` is 1 in every cycle after reset, so every byte offered with `rx_valid` high is consumed in that cycle.
- R3: When `ser_mode` equals 0 or `filt_en` is 0, a consumed byte sets `rx_flag` at the next clock edge whatever its value.
- R4: When filtering is active, a consumed byte sets the flag if (address AND mask) equals (byte AND mask).
- R5: When filtering is active, a consumed byte sets the flag if every 1 bit of the broadcast pattern (address OR mask) is also 1 in the byte.
- R6: When filtering is active and a consumed byte matches neither the individual nor the broadcast test, `rx_flag` keeps its value, whether that value is 0 or 1.
- R7: `rx_flag` holds at 1 until `flag_clr` is high at a clock edge; it then reads 0 from the next cycle.
- R8: When `flag_clr` and a byte that sets the flag occur in the same cycle, the flag is 1 afterwards, because the set wins.
- R9: With both registers at their reset value 0, every byte matches even with filtering active.
- R10: A write through `adr_we` or `msk_we` takes effect from the next cycle on. A byte consumed in the same cycle as a write is compared against the old register values.
- R11: In a cycle with neither `rx_valid` nor `flag_clr` high, `rx_flag` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Always 1; the block never stalls the stream |
| rx_data | input | DATA_W | Received byte |
| ser_mode | input | MODE_W | Serial mode field; 0 disables filtering |
| filt_en | input | 1 | Multiprocessor filter enable |
| adr_we | input | 1 | Write strobe for the slave address register |
| adr_wdata | input | DATA_W | New slave address |
| msk_we | input | 1 | Write strobe for the mask register |
| msk_wdata | input | DATA_W | New mask |
| flag_clr | input | 1 | Software clear of the receive flag |
| rx_flag | output | 1 | Receive-interrupt flag |

## Verification
On every cycle, the assertions check four things: that the flag follows the pass-through rule, the individual and broadcast matches, and the hold-on-miss rule, using a shadow of the two registers built from the write ports. They also check that a clear without a byte drops the flag, that a set beats a simultaneous clear, and that the flag stays still in idle cycles. Some behaviour depends on ordering across cycles, and only the bench's scenarios show it. This covers the old-value comparison when a register write meets a byte, the all-pass behaviour of the reset register values, and a flag that stays at 1 across missed bytes.

// File: rtl/uart_addr_filter_pkg.sv
package uart_addr_filter_pkg;

  // Outcome of comparing one byte against the programmed address.
  typedef struct packed {
    logic indiv;
    logic bcast;
  } match_t;

endpackage

// File: rtl/uaf_addr_regs.sv
module uaf_addr_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_we,
  input  logic [DATA_W-1:0] adr_wdata,
  input  logic              msk_we,
  input  logic [DATA_W-1:0] msk_wdata,
  output logic [DATA_W-1:0] adr_q,
  output logic [DATA_W-1:0] msk_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q <= '0;
      msk_q <= '0;
    end else begin
      if (adr_we) adr_q <= adr_wdata;
      if (msk_we) msk_q <= msk_wdata;
    end
  end

endmodule

// File: rtl/uaf_match.sv
module uaf_match
  import uart_addr_filter_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] adr,
  input  logic [DATA_W-1:0] msk,
  input  logic [DATA_W-1:0] data,
  output match_t            hit
);

  logic [DATA_W-1:0] miss_ind;
  logic [DATA_W-1:0] miss_bc;

  // Per-bit miss terms: a compared bit that differs, or a broadcast bit absent.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign miss_ind[i] = msk[i] & (adr[i] ^ data[i]);
    assign miss_bc[i]  = (adr[i] | msk[i]) & ~data[i];
  end

  assign hit.indiv = ~|miss_ind;
  assign hit.bcast = ~|miss_bc;

endmodule

// File: rtl/uaf_flag.sv
module uaf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;   // set has priority over clear
    else if (clr_i) flag_q <= 1'b0;
  end

endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
  import uart_addr_filter_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [MODE_W-1:0] ser_mode,
  input  logic              filt_en,
  input  logic              adr_we,
  input  logic [DATA_W-1:0] adr_wdata,
  input  logic              msk_we,
  input  logic [DATA_W-1:0] msk_wdata,
  input  logic              flag_clr,
  output logic              rx_flag
);

  logic [DATA_W-1:0] adr_q;
  logic [DATA_W-1:0] msk_q;
  match_t            hit;
  logic              filter_on;
  logic              accept;
  logic              set_flag;

  uaf_addr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .adr_we    (adr_we),
    .adr_wdata (adr_wdata),
    .msk_we    (msk_we),
    .msk_wdata (msk_wdata),
    .adr_q     (adr_q),
    .msk_q     (msk_q)
  );

  uaf_match #(.DATA_W(DATA_W)) u_match (
    .adr  (adr_q),
    .msk  (msk_q),
    .data (rx_data),
    .hit  (hit)
  );

  assign rx_ready  = 1'b1;
  assign filter_on = (ser_mode != '0) && filt_en;
  assign accept    = !filter_on || hit.indiv || hit.bcast;
  assign set_flag  = rx_valid && rx_ready && accept;

  uaf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_flag),
    .clr_i  (flag_clr),
    .flag_q (rx_flag)
  );

endmodule

// File: rtl/uart_addr_filter_chk.sv
module uart_addr_filter_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic [MODE_W-1:0] ser_mode,
  input logic              filt_en,
  input logic              adr_we,
  input logic [DATA_W-1:0] adr_wdata,
  input logic              msk_we,
  input logic [DATA_W-1:0] msk_wdata,
  input logic              flag_clr,
  input logic              rx_flag
);

  // Shadow of the programmed values, rebuilt from the write ports.
  logic [DATA_W-1:0] sh_adr;
  logic [DATA_W-1:0] sh_msk;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_adr <= '0;
      sh_msk <= '0;
    end else begin
      if (adr_we) sh_adr <= adr_wdata;
      if (msk_we) sh_msk <= msk_wdata;
    end
  end

  logic active, ind_ok, bc_ok;
  assign active = (ser_mode != '0) && filt_en;
  assign ind_ok = ((sh_adr & sh_msk) == (rx_data & sh_msk));
  assign bc_ok  = (((sh_adr | sh_msk) & rx_data) == (sh_adr | sh_msk));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !active |=> rx_flag);

  p_indiv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && active && ind_ok |=> rx_flag);

  p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && active && bc_ok |=> rx_flag);

  p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && active && !ind_ok && !bc_ok && !flag_clr |=> $stable(rx_flag));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !rx_valid |=> !rx_flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && rx_valid && (!active || ind_ok || bc_ok) |=> rx_flag);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && !flag_clr |=> $stable(rx_flag));

  p_ready_consume_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(rx_valid) && $past(rx_ready));

endmodule

bind uart_addr_filter uart_addr_filter_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .ser_mode  (ser_mode),
  .filt_en   (filt_en),
  .adr_we    (adr_we),
  .adr_wdata (adr_wdata),
  .msk_we    (msk_we),
  .msk_wdata (msk_wdata),
  .flag_clr  (flag_clr),
  .rx_flag   (rx_flag)
);

// File: tb/uart_addr_filter_test.sv
module uart_addr_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = '0;
  logic [1:0] ser_mode = '0;
  logic       filt_en = 1'b0;
  logic       adr_we = 1'b0;
  logic [7:0] adr_wdata = '0;
  logic       msk_we = 1'b0;
  logic [7:0] msk_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       rx_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Behavioural reference state
  int m_adr = 0;
  int m_msk = 0;
  int m_flag = 0;

  always #10 clk = ~clk;

  uart_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .ser_mode(ser_mode), .filt_en(filt_en),
    .adr_we(adr_we), .adr_wdata(adr_wdata), .msk_we(msk_we),
    .msk_wdata(msk_wdata), .flag_clr(flag_clr), .rx_flag(rx_flag)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus (called at a falling edge), advance the
  // model at the rising edge, compare at the next falling edge.
  task automatic step(input bit v, input int d, input int m, input bit en,
                      input bit aw, input int ad, input bit mw, input int md,
                      input bit clr, input string tag);
    bit pass, ind, bc;
    int bcp;
    rx_valid = v; rx_data = d[7:0]; ser_mode = m[1:0]; filt_en = en;
    adr_we = aw; adr_wdata = ad[7:0]; msk_we = mw; msk_wdata = md[7:0];
    flag_clr = clr;
    @(posedge clk);
    bcp  = (m_adr | m_msk) & 255;
    ind  = ((m_adr & m_msk) == (d & m_msk));
    bc   = ((d & bcp) == bcp);
    pass = (m == 0) || !en || ind || bc;
    if (v && pass) m_flag = 1;
    else if (clr)  m_flag = 0;
    if (aw) m_adr = ad & 255;
    if (mw) m_msk = md & 255;
    @(negedge clk);
    check({tag, " flag"}, int'(rx_flag), m_flag);
    check("R2 ready", int'(rx_ready), 1);
    rx_valid = 0; adr_we = 0; msk_we = 0; flag_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag in reset", int'(rx_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after release", int'(rx_flag), 0);

    // R9: registers at zero, filtering active: any byte passes
    step(1, 8'h5A, 1, 1, 0, 0, 0, 0, 0, "R9 zero regs pass");
    check("R9 explicit", int'(rx_flag), 1);
    // R11 idle keeps 1, R7 clear drops it
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R11 idle hold");
    step(0, 0, 1, 1, 0, 0, 0, 0, 1, "R7 clear");
    check("R7 explicit cleared", int'(rx_flag), 0);

    // Program address 0x12, mask 0xF0 (broadcast pattern 0xF2)
    step(0, 0, 1, 1, 1, 8'h12, 1, 8'hF0, 0, "R10 write");
    step(1, 8'h1F, 1, 1, 0, 0, 0, 0, 0, "R4 individual match");
    check("R4 explicit", int'(rx_flag), 1);
    step(0, 0, 1, 1, 0, 0, 0, 0, 1, "R7 clear");
    step(1, 8'h2F, 1, 1, 0, 0, 0, 0, 0, "R6 miss keeps 0");
    check("R6 explicit stays 0", int'(rx_flag), 0);
    step(1, 8'hF7, 3, 1, 0, 0, 0, 0, 0, "R5 broadcast match");
    check("R5 explicit", int'(rx_flag), 1);
    step(1, 8'h2F, 2, 1, 0, 0, 0, 0, 0, "R6 miss keeps 1");
    check("R6 explicit stays 1", int'(rx_flag), 1);
    step(0, 0, 1, 1, 0, 0, 0, 0, 1, "R7 clear");

    // R3: mode zero, then enable low
    step(1, 8'h2F, 0, 1, 0, 0, 0, 0, 0, "R3 mode zero");
    check("R3 explicit mode zero", int'(rx_flag), 1);
    step(0, 0, 0, 1, 0, 0, 0, 0, 1, "R7 clear");
    step(1, 8'h2F, 2, 0, 0, 0, 0, 0, 0, "R3 enable low");

    // R8: clear and passing byte together
    step(1, 8'h10, 1, 1, 0, 0, 0, 0, 1, "R8 set beats clear");
    check("R8 explicit", int'(rx_flag), 1);
    step(0, 0, 1, 1, 0, 0, 0, 0, 1, "R7 clear");

    // R10: byte in the write cycle uses old values (0x12/0xF0 -> match)
    step(1, 8'h12, 1, 1, 1, 8'h55, 1, 8'hFF, 0, "R10 old values");
    check("R10 explicit old", int'(rx_flag), 1);
    step(0, 0, 1, 1, 0, 0, 0, 0, 1, "R7 clear");
    step(1, 8'h12, 1, 1, 0, 0, 0, 0, 0, "R10 new values");
    check("R10 explicit new", int'(rx_flag), 0);
    step(1, 8'hFF, 1, 1, 0, 0, 0, 0, 0, "R5 all ones broadcast");

    // Mixed scenarios against the reference model
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step(r[0], $urandom & 255, (r >> 1) & 3, r[3] | r[4],
           (r[9:5] == 0), $urandom & 255, (r[14:10] == 0),
           (r[15] ? 8'hF0 : $urandom & 255), (r[18:16] == 0), "R4 R5 R6 mixed");
    end

    finish_run();
  end

endmodule